// File: doc/BRIEF.md
# Serial Peripheral Interrupt Collector with Soft Reset

This unit gathers six event lines from a serial peripheral core into one interrupt request. The rising edge of each event line latches a sticky status bit. Each status bit is masked by its own enable bit, and the masked result is gated by a single global enable. Software acknowledges an event by writing ones to the status register at that bit's position. This lets a handler write back exactly the value it has just read.

A separate write-only register gives software a way to reset the attached core. A write with one specific key value produces a single-cycle reset pulse on `core_rst` and also wipes the status register. Any other value written there is ignored. Register access uses plain read and write strobes with a byte offset. Read data is combinational and is driven only while the read strobe is high.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, the status, enable and global-enable registers read as zero, and `irq` and `core_rst` are low.
- R2: A 0-to-1 transition on `events[i]` sets status bit i at the next clock edge. A level that stays high does not set the bit again once it has been cleared. Bit meanings: 0 mode fault, 1 slave-mode fault, 2 transmit FIFO empty, 3 transmit underrun, 4 receive FIFO full, 5 receive overrun.
- R3: A status bit stays set after its event line falls, until it is cleared by R4 or R9.
- R4: A write to offset 0x20 clears the status bits whose positions are 1 in `wdata[5:0]` and leaves the other bits unchanged. The status register reads back at offset 0x20 in bits [5:0].
- R5: When a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: The per-source enable register is at offset 0x28, bits [5:0]. It reads back with zeros in bits [31:6].
- R7: The global enable is bit 31 at offset 0x1C. All other bits of that register read as zero.
- R8: `irq` is high exactly when the global enable is set and at least one status bit has its enable bit set. It follows register changes in the same cycle.
- R9: Writing exactly 32'h0000000A to offset 0x40 raises `core_rst` for the one cycle after that clock edge. The same edge clears all status bits, except bits that rise in that cycle. The enable and global-enable registers keep their values.
- R10: Writing any other value to offset 0x40, or writing to an unmapped offset, changes no register and gives no `core_rst` pulse.
- R11: Reads of offset 0x40 and of unmapped offsets return zero. `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| events | input | 6 | Event lines from the peripheral core |
| irq | output | 1 | Interrupt request |
| core_rst | output | 1 | One-cycle reset pulse to the core |

## Verification
Event edges and register writes are sampled at a clock edge. Their effects on status, `irq` and `core_rst` appear right after that same edge, so the bench drives inputs on the falling edge. It updates its model at the rising edge and compares at the next falling edge. Read data is combinational, so reads are checked 1 ns after `addr` and `rd_en` are set, between edges. The `core_rst` pulse is checked high in the cycle after the key write and low in the cycle after that.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int NSRC   = 6;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef logic [NSRC-1:0]   src_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  localparam addr_t OFF_GIE  = 8'h1C;
  localparam addr_t OFF_STAT = 8'h20;
  localparam addr_t OFF_EN   = 8'h28;
  localparam addr_t OFF_SRST = 8'h40;
  localparam word_t SRST_KEY = 32'h0000_000A;
  localparam int    GIE_BIT  = DATA_W - 1;

  // next sticky status: clears first, fresh edges win
  function automatic src_t status_next(src_t cur, src_t clr, logic wipe, src_t rise);
    return (cur & ~clr & ~{NSRC{wipe}}) | rise;
  endfunction

  function automatic logic irq_reduce(src_t st, src_t en, logic gie);
    return gie & (|(st & en));
  endfunction
endpackage

// File: rtl/evt_edge_capture.sv
module evt_edge_capture
  import evt_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t ev,
  output src_t rise
);
  src_t ev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q[i] <= 1'b0;
      else        ev_q[i] <= ev[i];
    end
    assign rise[i] = ev[i] & ~ev_q[i];
  end

  // R2
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0) || !$stable(ev));
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_t rise,
  input  src_t clr,
  input  logic wipe,
  output src_t status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_next(status, clr, wipe, rise);
  end

  // R2
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));
  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0 && !wipe) |=> ((status & $past(status)) == $past(status)));
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~rise)) |=> ((status & $past(clr & ~rise)) == '0));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & clr)) |=> ((status & $past(rise & clr)) == $past(rise & clr)));
endmodule

// File: rtl/evt_soft_reset.sv
module evt_soft_reset
  import evt_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst_wr,
  input  word_t wdata,
  output logic  wipe,
  output logic  core_rst
);
  assign wipe = srst_wr && (wdata == SRST_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst <= 1'b0;
    else        core_rst <= wipe;
  end

  // R9
  pulse_follows_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> core_rst);
  // R10
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> $past(srst_wr && wdata == SRST_KEY));
endmodule

// File: rtl/evt_reg_file.sv
module evt_reg_file
  import evt_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  addr_t addr,
  input  word_t wdata,
  input  src_t  status,
  output src_t  en,
  output logic  gie,
  output src_t  clr,
  output logic  srst_wr,
  output word_t rdata
);
  logic wr_en_reg, wr_gie_reg;

  assign wr_en_reg  = wr_en && (addr == OFF_EN);
  assign wr_gie_reg = wr_en && (addr == OFF_GIE);
  assign srst_wr    = wr_en && (addr == OFF_SRST);
  assign clr        = (wr_en && addr == OFF_STAT) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      gie <= 1'b0;
    end else begin
      if (wr_en_reg)  en  <= wdata[NSRC-1:0];
      if (wr_gie_reg) gie <= wdata[GIE_BIT];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_GIE:  rdata[GIE_BIT]  = gie;
        OFF_STAT: rdata[NSRC-1:0] = status;
        OFF_EN:   rdata[NSRC-1:0] = en;
        default:  rdata = '0;
      endcase
    end
  end

  // R6
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> (en == $past(wdata[NSRC-1:0])));
  // R7
  gie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gie_reg |=> $stable(gie));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != OFF_GIE && addr != OFF_STAT && addr != OFF_EN) |-> (rdata == '0));
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [5:0]  events,
  output logic        irq,
  output logic        core_rst
);
  src_t rise, clr, status, en;
  logic gie, wipe, srst_wr;

  evt_edge_capture u_edge (
    .clk(clk), .rst_n(rst_n), .ev(events), .rise(rise)
  );

  evt_status_bank u_status (
    .clk(clk), .rst_n(rst_n), .rise(rise), .clr(clr), .wipe(wipe), .status(status)
  );

  evt_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .status(status), .en(en), .gie(gie), .clr(clr),
    .srst_wr(srst_wr), .rdata(rdata)
  );

  evt_soft_reset u_srst (
    .clk(clk), .rst_n(rst_n), .srst_wr(srst_wr), .wdata(wdata),
    .wipe(wipe), .core_rst(core_rst)
  );

  assign irq = irq_reduce(status, en, gie);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0 || !gie || en == '0) |-> !irq);
  // R9
  wipe_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && !wr_en_any()) |=> $stable(en));

  function automatic logic wr_en_any();
    return 1'b0;
  endfunction
endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  events = '0;
  logic        irq, core_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [5:0] m_stat = '0, m_en = '0, m_prev = '0;
  logic       m_gie = 1'b0, m_rst = 1'b0;

  always #4 clk = ~clk;

  evt_irq_hub u_evt_irq_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .events(events), .irq(irq), .core_rst(core_rst)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic model_irq();
    logic any = 1'b0;
    for (int i = 0; i < 6; i++) if (m_stat[i] && m_en[i]) any = 1'b1;
    return any && m_gie;
  endfunction

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cycle(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input logic [5:0] ev);
    bit key;
    wr_en = we; addr = a; wdata = d; events = ev;
    @(posedge clk);
    key = we && a == 8'h40 && d == 32'hA;
    for (int i = 0; i < 6; i++) begin
      logic up = ev[i] && !m_prev[i];
      logic cl = key || (we && a == 8'h20 && d[i]);
      if (up) m_stat[i] = 1'b1;
      else if (cl) m_stat[i] = 1'b0;
    end
    m_prev = ev;
    m_rst = key;
    if (we && a == 8'h28) m_en = d[5:0];
    if (we && a == 8'h1C) m_gie = d[31];
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 irq", {31'b0, irq}, {31'b0, model_irq()});
    chk("R9/R10 core_rst", {31'b0, core_rst}, {31'b0, m_rst});
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 core_rst", {31'b0, core_rst}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 status", 8'h20, 32'h0);
    rd("R1 enable", 8'h28, 32'h0);
    rd("R1 gie", 8'h1C, 32'h0);

    // R2 edges set bits; held level does not re-set
    cycle(0, 8'h00, 0, 6'b000101);
    rd("R2 status after edge", 8'h20, 32'h05);
    cycle(0, 8'h00, 0, 6'b000101);
    // R4 write-back clear
    cycle(1, 8'h20, 32'h05, 6'b000101);
    rd("R4 cleared", 8'h20, 32'h00);
    cycle(0, 8'h00, 0, 6'b000101);
    rd("R2 held level no reset", 8'h20, 32'h00);
    cycle(0, 8'h00, 0, 6'b000000);

    // R3 sticky after event drops
    cycle(0, 8'h00, 0, 6'b100000);
    repeat (3) cycle(0, 8'h00, 0, 6'b000000);
    rd("R3 sticky", 8'h20, 32'h20);

    // R8 gating, R6/R7 readback
    cycle(1, 8'h28, 32'h20, 6'b0);
    chk("R8 no gie", {31'b0, irq}, 32'h0);
    cycle(1, 8'h1C, 32'h8000_0000, 6'b0);
    chk("R8 irq up", {31'b0, irq}, 32'h1);
    rd("R7 gie read", 8'h1C, 32'h8000_0000);
    rd("R6 en read", 8'h28, 32'h20);
    cycle(1, 8'h1C, 32'h7FFF_FFFF, 6'b0);
    chk("R7 gie off", {31'b0, irq}, 32'h0);
    cycle(1, 8'h28, 32'hFFFF_FFFF, 6'b0);
    rd("R6 upper zero", 8'h28, 32'h3F);
    cycle(1, 8'h1C, 32'h8000_0000, 6'b0);

    // R5 set beats clear
    cycle(0, 8'h00, 0, 6'b000010);
    cycle(0, 8'h00, 0, 6'b000000);
    cycle(1, 8'h20, 32'h02, 6'b000010);
    rd("R5 set wins", 8'h20, 32'h22);
    cycle(0, 8'h00, 0, 6'b000000);

    // R10 wrong key / wrong address
    cycle(1, 8'h40, 32'h0000_010A, 6'b0);
    chk("R10 no pulse", {31'b0, core_rst}, 32'h0);
    cycle(1, 8'h40, 32'h0000_000B, 6'b0);
    cycle(1, 8'h44, 32'h0000_000A, 6'b0);
    chk("R10 no pulse other addr", {31'b0, core_rst}, 32'h0);
    rd("R10 status kept", 8'h20, 32'h22);

    // R9 key write
    cycle(1, 8'h40, 32'h0000_000A, 6'b0);
    chk("R9 pulse high", {31'b0, core_rst}, 32'h1);
    rd("R9 status wiped", 8'h20, 32'h0);
    rd("R9 en kept", 8'h28, 32'h3F);
    cycle(0, 8'h00, 0, 6'b0);
    chk("R9 pulse one cycle", {31'b0, core_rst}, 32'h0);

    // R11 unmapped and idle reads
    rd("R11 srst reads zero", 8'h40, 32'h0);
    rd("R11 unmapped 0x24", 8'h24, 32'h0);
    rd("R11 unmapped 0x00", 8'h00, 32'h0);
    addr = 8'h28; #1;
    chk("R11 rd_en low", rdata, 32'h0);

    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [5:0] ev = events;
      int op = $urandom % 10;
      if ($urandom % 3 == 0) ev = ev ^ 6'($urandom);
      case (op)
        0: cycle(1, 8'h20, $urandom, ev);
        1: cycle(1, 8'h28, $urandom, ev);
        2: cycle(1, 8'h1C, $urandom, ev);
        3: cycle(1, 8'h40, ($urandom % 2) ? 32'hA : ($urandom % 16), ev);
        default: cycle(0, 8'h00, 0, ev);
      endcase
      if (n % 8 == 0) begin
        rd("R2/R4 status model", 8'h20, {26'b0, m_stat});
        rd("R6 en model", 8'h28, {26'b0, m_en});
        rd("R7 gie model", 8'h1C, {m_gie, 31'b0});
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule